// File: doc/BRIEF.md
# Uniform/Affine Register Tag Tracker

This block follows, for every architectural register of a SIMT core, what is known about the values that register holds across the lanes of a warp. A register is classed as uniform when every lane holds the same value. It is classed as affine when lane `t` holds `base + t*stride`. Otherwise it is a generic vector. Uniform registers keep their single value in the base field. Affine registers keep a (base, stride) pair, so the full per-lane vector is never stored.

Launch code seeds the tags through a seed port. The register that carries the thread index is seeded affine with base 0 and stride 1, and broadcast constants such as kernel parameters and literals are seeded uniform. After launch, each issued ALU operation (add, multiply, shift-left) reads the tags and metadata of its two sources. The block applies a deliberately conservative rule table to produce the destination class, base and stride. It writes them back in the same cycle that the result is registered, and reports the execution class: scalar, affine or full vector.

An affine result written while the warp is diverged is not trusted. It is marked stale and is expanded lazily the first time it is read: the reading operation sees it as a vector, an expand flag is raised for that operand, and the register is demoted to vector from then on.

Top module: `uat_tracker`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and every register is tagged vector, so an operation on unseeded registers reports class vector. The class encoding is uniform = 0, affine = 1, vector = 2.
- R2: A seed write stores uniform (`seed_uniform`=1, value in base, stride 0) or affine (base and stride taken from the port) and clears any stale mark. When `seed_en` and `op_valid` are both high, the seed wins and the operation is dropped: `out_valid` stays 0 and no register changes except the seeded one.
- R3: Add (`op_code`=0): uniform+uniform gives uniform with base a+b. Uniform+affine, in either operand order, gives affine with base equal to the uniform value plus the affine base, and the affine stride. Affine+affine gives vector, and any vector operand gives vector.
- R4: Multiply (`op_code`=1): only uniform×uniform gives uniform, with base a×b (low W bits). Every other combination, including uniform×affine, gives vector.
- R5: Shift-left (`op_code`=2): uniform<<uniform gives uniform with base a<<b (0 when b ≥ W). Uniform<<affine gives affine, with base u<<base and stride (u<<(base+stride)) − (u<<base). Affine<<uniform and anything involving a vector gives vector.
- R6: The result of an operation issued in cycle t appears on the outputs after the clock edge that ends cycle t, and the destination tag is already updated for an operation issued in cycle t+1. This includes a destination that equals a source.
- R7: An affine result written with `op_diverged`=1 is reported as affine. The next operation that reads that register treats it as vector and raises `out_expand_a` or `out_expand_b` for that operand.
- R8: A stale register is expanded only once. After the first read it is a plain vector, and later reads raise no expand flag. When the reading operation also writes that register, the new destination tag wins.
- R9: Uniform and vector results written under divergence are stored normally and raise no expand flag when read.
- R10: The reserved `op_code`=3 always gives vector.
- R11: A vector result reports base 0 and stride 0, and a uniform result reports stride 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_en | input | 1 | Launch seed write strobe |
| seed_idx | input | RW | Register being seeded |
| seed_uniform | input | 1 | 1 = seed uniform, 0 = seed affine |
| seed_base | input | W | Uniform value or affine base |
| seed_stride | input | W | Affine stride (ignored for uniform) |
| op_valid | input | 1 | ALU operation issued this cycle |
| op_code | input | 2 | 0 add, 1 multiply, 2 shift-left, 3 reserved |
| op_src_a | input | RW | First source register |
| op_src_b | input | RW | Second source register |
| op_dst | input | RW | Destination register |
| op_diverged | input | 1 | Warp is executing under divergence |
| out_valid | output | 1 | Result registers hold a new result |
| out_class | output | 2 | Execution class: 0 scalar, 1 affine, 2 vector |
| out_dst | output | RW | Destination of the reported result |
| out_base | output | W | Uniform value or affine base of the result |
| out_stride | output | W | Affine stride of the result |
| out_expand_a | output | 1 | First source was stale affine and must be expanded |
| out_expand_b | output | 1 | Second source was stale affine and must be expanded |

## Verification
The bench tests the rule table in both operand orders, because a tracker that made the rules symmetric would wrongly return affine for affine<<uniform or vector for affine+uniform. Chained operations read results written one cycle earlier, including a destination that equals its own source. A design that read stale tag state would report the previous class or value there. The divergence sequence writes a stale affine, reads it twice and then reads it while overwriting it. A design that missed the lazy expansion would report affine, and one that did not demote the register would raise the expand flag again. A seed issued in the same cycle as an operation must suppress that operation, and a shift by 40 must yield 0, not the amount taken modulo the width.

// File: rtl/uat_pkg.sv
package uat_pkg;

  typedef enum logic [1:0] {
    TAG_U = 2'd0,
    TAG_A = 2'd1,
    TAG_V = 2'd2
  } tag_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_SHL = 2'd2,
    OP_RSV = 2'd3
  } op_e;

endpackage

// File: rtl/uat_tag_store.sv
module uat_tag_store
  import uat_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  tag_e          wr_tag,
  input  logic          wr_stale,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_a_idx,
  input  logic [RW-1:0] rd_b_idx,
  output tag_e          rd_a_tag,
  output tag_e          rd_b_tag,
  output logic          rd_a_stale,
  output logic          rd_b_stale
);

  tag_e            tag_q   [NREG];
  logic [NREG-1:0] stale_q;

  // Tags live in flops so that a read can demote a register in the same
  // cycle that the write port updates another one.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) tag_q[i] <= TAG_V;
      stale_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && wr_idx == RW'(i)) begin
          tag_q[i]   <= wr_tag;
          stale_q[i] <= wr_stale;
        end else if (rd_en && stale_q[i] &&
                     (rd_a_idx == RW'(i) || rd_b_idx == RW'(i))) begin
          tag_q[i]   <= TAG_V;
          stale_q[i] <= 1'b0;
        end
      end
    end
  end

  assign rd_a_stale = stale_q[rd_a_idx];
  assign rd_b_stale = stale_q[rd_b_idx];
  assign rd_a_tag   = rd_a_stale ? TAG_V : tag_q[rd_a_idx];
  assign rd_b_tag   = rd_b_stale ? TAG_V : tag_q[rd_b_idx];

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R7: only an affine register can carry the untrusted mark
    a_r7_stale_is_affine: assert property (@(posedge clk) disable iff (rst)
      stale_q[g] |-> tag_q[g] == TAG_A);
  end

endmodule

// File: rtl/uat_meta_ram.sv
module uat_meta_ram #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG),
  parameter int W    = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [W-1:0]  wr_base,
  input  logic [W-1:0]  wr_stride,
  input  logic [RW-1:0] rd_a_idx,
  input  logic [RW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_a_base,
  output logic [W-1:0]  rd_a_stride,
  output logic [W-1:0]  rd_b_base,
  output logic [W-1:0]  rd_b_stride
);

  localparam int EW = 2 * W;

  // One write port, two asynchronous read ports: maps to distributed RAM.
  logic [EW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_base, wr_stride};
  end

  assign {rd_a_base, rd_a_stride} = mem[rd_a_idx];
  assign {rd_b_base, rd_b_stride} = mem[rd_b_idx];

endmodule

// File: rtl/uat_combine.sv
module uat_combine
  import uat_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  tag_e         ta,
  input  tag_e         tb,
  input  logic [W-1:0] a_base,
  input  logic [W-1:0] a_stride,
  input  logic [W-1:0] b_base,
  input  logic [W-1:0] b_stride,
  output tag_e         cls,
  output logic [W-1:0] base,
  output logic [W-1:0] stride
);

  logic [W-1:0] sum_ab, prod_ab, shl_ab, shl_lane1;

  assign sum_ab    = a_base + b_base;
  assign prod_ab   = a_base * b_base;
  assign shl_ab    = a_base << b_base;
  assign shl_lane1 = a_base << (b_base + b_stride);

  always_comb begin
    cls    = TAG_V;
    base   = '0;
    stride = '0;
    unique case (op)
      OP_ADD: begin
        if (ta == TAG_U && tb == TAG_U) begin
          cls  = TAG_U;
          base = sum_ab;
        end else if (ta == TAG_U && tb == TAG_A) begin
          cls    = TAG_A;
          base   = sum_ab;
          stride = b_stride;
        end else if (ta == TAG_A && tb == TAG_U) begin
          cls    = TAG_A;
          base   = sum_ab;
          stride = a_stride;
        end
      end
      OP_MUL: begin
        if (ta == TAG_U && tb == TAG_U) begin
          cls  = TAG_U;
          base = prod_ab;
        end
      end
      OP_SHL: begin
        if (ta == TAG_U && tb == TAG_U) begin
          cls  = TAG_U;
          base = shl_ab;
        end else if (ta == TAG_U && tb == TAG_A) begin
          cls    = TAG_A;
          base   = shl_ab;
          stride = shl_lane1 - shl_ab;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/uat_tracker.sv
module uat_tracker
  import uat_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seed_en,
  input  logic [RW-1:0] seed_idx,
  input  logic          seed_uniform,
  input  logic [W-1:0]  seed_base,
  input  logic [W-1:0]  seed_stride,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [RW-1:0] op_src_a,
  input  logic [RW-1:0] op_src_b,
  input  logic [RW-1:0] op_dst,
  input  logic          op_diverged,
  output logic          out_valid,
  output logic [1:0]    out_class,
  output logic [RW-1:0] out_dst,
  output logic [W-1:0]  out_base,
  output logic [W-1:0]  out_stride,
  output logic          out_expand_a,
  output logic          out_expand_b
);

  tag_e         ta, tb, res_cls, wr_tag;
  logic         a_stale, b_stale, issue, wr_en, wr_stale;
  logic [W-1:0] a_base, a_stride, b_base, b_stride;
  logic [W-1:0] res_base, res_stride, wr_base, wr_stride;
  logic [RW-1:0] wr_idx;

  // The seed has priority on the single write port; a colliding op is dropped.
  assign issue = op_valid && !seed_en;
  assign wr_en = seed_en || issue;

  always_comb begin
    if (seed_en) begin
      wr_idx    = seed_idx;
      wr_tag    = seed_uniform ? TAG_U : TAG_A;
      wr_base   = seed_base;
      wr_stride = seed_uniform ? '0 : seed_stride;
      wr_stale  = 1'b0;
    end else begin
      wr_idx    = op_dst;
      wr_tag    = res_cls;
      wr_base   = res_base;
      wr_stride = res_stride;
      wr_stale  = op_diverged && res_cls == TAG_A;
    end
  end

  uat_tag_store #(.NREG(NREG), .RW(RW)) u_tags (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_stale(wr_stale),
    .rd_en(issue), .rd_a_idx(op_src_a), .rd_b_idx(op_src_b),
    .rd_a_tag(ta), .rd_b_tag(tb), .rd_a_stale(a_stale), .rd_b_stale(b_stale)
  );

  uat_meta_ram #(.NREG(NREG), .RW(RW), .W(W)) u_meta (
    .clk(clk),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_stride(wr_stride),
    .rd_a_idx(op_src_a), .rd_b_idx(op_src_b),
    .rd_a_base(a_base), .rd_a_stride(a_stride),
    .rd_b_base(b_base), .rd_b_stride(b_stride)
  );

  uat_combine #(.W(W)) u_comb (
    .op(op_e'(op_code)), .ta(ta), .tb(tb),
    .a_base(a_base), .a_stride(a_stride), .b_base(b_base), .b_stride(b_stride),
    .cls(res_cls), .base(res_base), .stride(res_stride)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_class    <= TAG_V;
      out_dst      <= '0;
      out_base     <= '0;
      out_stride   <= '0;
      out_expand_a <= 1'b0;
      out_expand_b <= 1'b0;
    end else begin
      out_valid    <= issue;
      out_class    <= res_cls;
      out_dst      <= op_dst;
      out_base     <= res_base;
      out_stride   <= res_stride;
      out_expand_a <= issue && a_stale;
      out_expand_b <= issue && b_stale;
    end
  end

  // R6: a result is reported only for an op issued one cycle earlier
  a_r6_result_has_issue: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(op_valid));

  // R2: a seed in the previous cycle leaves no result behind
  a_r2_seed_blocks_issue: assert property (@(posedge clk) disable iff (rst)
    $past(seed_en) |-> !out_valid);

  // R11: vector results carry no metadata
  a_r11_vector_zero_meta: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == TAG_V) |-> (out_base == '0 && out_stride == '0));

  // R11: uniform results carry no stride
  a_r11_uniform_no_stride: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == TAG_U) |-> out_stride == '0);

  // R4: multiply never produces affine
  a_r4_mul_not_affine: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_code) == OP_MUL) |-> out_class != TAG_A);

  // R10: reserved opcode is always vector
  a_r10_reserved_vector: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_code) == OP_RSV) |-> out_class == TAG_V);

  // R7: an expand flag only accompanies a vector-class result
  a_r7_expand_means_vector: assert property (@(posedge clk) disable iff (rst)
    (out_expand_a || out_expand_b) |-> (out_valid && out_class == TAG_V));

endmodule

// File: tb/test_uat_tracker.sv
module test_uat_tracker;

  localparam int NREG = 32;
  localparam int W    = 32;
  localparam int RW   = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          seed_en = 1'b0, seed_uniform = 1'b0;
  logic [RW-1:0] seed_idx = '0;
  logic [W-1:0]  seed_base = '0, seed_stride = '0;
  logic          op_valid = 1'b0, op_diverged = 1'b0;
  logic [1:0]    op_code = '0;
  logic [RW-1:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
  logic          out_valid, out_expand_a, out_expand_b;
  logic [1:0]    out_class;
  logic [RW-1:0] out_dst;
  logic [W-1:0]  out_base, out_stride;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;  // 50 MHz

  uat_tracker #(.NREG(NREG), .W(W), .RW(RW)) i_uat_tracker (
    .clk(clk), .rst(rst),
    .seed_en(seed_en), .seed_idx(seed_idx), .seed_uniform(seed_uniform),
    .seed_base(seed_base), .seed_stride(seed_stride),
    .op_valid(op_valid), .op_code(op_code), .op_src_a(op_src_a),
    .op_src_b(op_src_b), .op_dst(op_dst), .op_diverged(op_diverged),
    .out_valid(out_valid), .out_class(out_class), .out_dst(out_dst),
    .out_base(out_base), .out_stride(out_stride),
    .out_expand_a(out_expand_a), .out_expand_b(out_expand_b)
  );

  localparam logic [1:0] CU = 2'd0, CA = 2'd1, CV = 2'd2;
  localparam logic [1:0] ADD = 2'd0, MUL = 2'd1, SHL = 2'd2, RSV = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  a, b, d;
    logic        div;
    logic [1:0]  cls;
    logic [31:0] base, stride;
    logic        ea, eb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // Seeds: r0 thread index A(0,1), r1 U5, r2 U3, r3 A(10,4), r4 U40
  localparam vec_t VEC [NV] = '{
    '{ADD, 5'd1,  5'd2,  5'd5,  1'b0, CU, 32'd8,  32'd0, 1'b0, 1'b0, 4'd3},  // R3 U+U
    '{ADD, 5'd1,  5'd0,  5'd6,  1'b0, CA, 32'd5,  32'd1, 1'b0, 1'b0, 4'd3},  // R3 U+A
    '{ADD, 5'd0,  5'd3,  5'd7,  1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd3},  // R3 A+A
    '{MUL, 5'd1,  5'd2,  5'd8,  1'b0, CU, 32'd15, 32'd0, 1'b0, 1'b0, 4'd4},  // R4 U*U
    '{MUL, 5'd1,  5'd0,  5'd9,  1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd4},  // R4 U*A
    '{SHL, 5'd2,  5'd1,  5'd10, 1'b0, CU, 32'd96, 32'd0, 1'b0, 1'b0, 4'd5},  // R5 U<<U
    '{SHL, 5'd1,  5'd0,  5'd11, 1'b0, CA, 32'd5,  32'd5, 1'b0, 1'b0, 4'd5},  // R5 U<<A
    '{SHL, 5'd0,  5'd1,  5'd12, 1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd5},  // R5 A<<U
    '{ADD, 5'd5,  5'd6,  5'd13, 1'b0, CA, 32'd13, 32'd1, 1'b0, 1'b0, 4'd6},  // R6 chained
    '{ADD, 5'd9,  5'd1,  5'd14, 1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd3},  // R3 V+U
    '{RSV, 5'd1,  5'd2,  5'd15, 1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd10}, // R10
    '{ADD, 5'd6,  5'd5,  5'd16, 1'b0, CA, 32'd13, 32'd1, 1'b0, 1'b0, 4'd3},  // R3 A+U
    '{ADD, 5'd1,  5'd0,  5'd17, 1'b1, CA, 32'd5,  32'd1, 1'b0, 1'b0, 4'd7},  // R7 written diverged
    '{ADD, 5'd17, 5'd1,  5'd18, 1'b0, CV, 32'd0,  32'd0, 1'b1, 1'b0, 4'd7},  // R7 first read
    '{ADD, 5'd17, 5'd1,  5'd19, 1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd8},  // R8 no second flag
    '{ADD, 5'd1,  5'd2,  5'd20, 1'b1, CU, 32'd8,  32'd0, 1'b0, 1'b0, 4'd9},  // R9 U diverged
    '{ADD, 5'd20, 5'd0,  5'd21, 1'b0, CA, 32'd8,  32'd1, 1'b0, 1'b0, 4'd9},  // R9 trusted
    '{SHL, 5'd1,  5'd4,  5'd22, 1'b0, CU, 32'd0,  32'd0, 1'b0, 1'b0, 4'd5},  // R5 shift >= W
    '{MUL, 5'd2,  5'd2,  5'd2,  1'b0, CU, 32'd9,  32'd0, 1'b0, 1'b0, 4'd6},  // R6 dst = src
    '{ADD, 5'd2,  5'd1,  5'd23, 1'b0, CU, 32'd14, 32'd0, 1'b0, 1'b0, 4'd6},  // R6 sees new r2
    '{ADD, 5'd1,  5'd0,  5'd24, 1'b1, CA, 32'd5,  32'd1, 1'b0, 1'b0, 4'd7},  // R7 stale r24
    '{ADD, 5'd1,  5'd24, 5'd24, 1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b1, 4'd8},  // R8 read+overwrite, port b
    '{ADD, 5'd24, 5'd1,  5'd25, 1'b0, CV, 32'd0,  32'd0, 1'b0, 1'b0, 4'd8}   // R8 no repeat
  };

  task automatic check(input string req, input logic [1:0] cls, input logic [W-1:0] b,
                       input logic [W-1:0] s, input logic ea, input logic eb,
                       input logic [RW-1:0] d);
    n_tests++;
    if (!(out_valid === 1'b1 && out_class === cls && out_base === b &&
          out_stride === s && out_expand_a === ea && out_expand_b === eb &&
          out_dst === d)) begin
      n_fail++;
      $display("FAIL %s: got v=%0b cls=%0d base=%0d stride=%0d ea=%0b eb=%0b dst=%0d, exp v=1 cls=%0d base=%0d stride=%0d ea=%0b eb=%0b dst=%0d",
               req, out_valid, out_class, out_base, out_stride, out_expand_a,
               out_expand_b, out_dst, cls, b, s, ea, eb, d);
    end
  endtask

  // Caller is at a negedge; the result is sampled at the following negedge.
  task automatic run_op(input logic [1:0] op, input logic [RW-1:0] a, input logic [RW-1:0] b,
                        input logic [RW-1:0] d, input logic div);
    op_valid = 1'b1; op_code = op; op_src_a = a; op_src_b = b; op_dst = d;
    op_diverged = div;
    @(negedge clk);
  endtask

  task automatic seed(input logic [RW-1:0] r, input logic u, input logic [W-1:0] b,
                      input logic [W-1:0] s);
    op_valid = 1'b0;
    seed_en = 1'b1; seed_idx = r; seed_uniform = u; seed_base = b; seed_stride = s;
    @(negedge clk);
    seed_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, exp at most 5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs idle after reset
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got out_valid=%0b, exp 0", out_valid);
    end
    // R1: unseeded registers are vector
    run_op(ADD, 5'd1, 5'd2, 5'd30, 1'b0);
    check("R1", CV, 0, 0, 1'b0, 1'b0, 5'd30);
    op_valid = 1'b0;

    seed(5'd0, 1'b0, 32'd0, 32'd1);
    seed(5'd1, 1'b1, 32'd5, 32'd0);
    seed(5'd2, 1'b1, 32'd3, 32'd0);
    seed(5'd3, 1'b0, 32'd10, 32'd4);
    seed(5'd4, 1'b1, 32'd40, 32'd77);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].d, VEC[i].div);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].cls, VEC[i].base,
            VEC[i].stride, VEC[i].ea, VEC[i].eb, VEC[i].d);
    end
    op_valid = 1'b0;
    op_diverged = 1'b0;
    @(negedge clk);

    // R2: a seed colliding with an op drops the op; only the seeded reg changes
    op_valid = 1'b1; op_code = ADD; op_src_a = 5'd1; op_src_b = 5'd2; op_dst = 5'd1;
    seed_en = 1'b1; seed_idx = 5'd26; seed_uniform = 1'b1; seed_base = 32'd100;
    @(negedge clk);
    seed_en = 1'b0; op_valid = 1'b0;
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: got out_valid=%0b, exp 0", out_valid);
    end
    run_op(ADD, 5'd26, 5'd1, 5'd27, 1'b0);  // r1 must still be U5
    check("R2 collided", CU, 32'd105, 0, 1'b0, 1'b0, 5'd27);

    // R2: reseeding a stale register clears the stale mark
    run_op(ADD, 5'd1, 5'd0, 5'd28, 1'b1);
    check("R7 setup", CA, 32'd5, 32'd1, 1'b0, 1'b0, 5'd28);
    seed(5'd28, 1'b1, 32'd7, 32'd0);
    run_op(ADD, 5'd28, 5'd1, 5'd29, 1'b0);
    check("R2 reseed", CU, 32'd12, 0, 1'b0, 1'b0, 5'd29);

    // R2: affine seed base/stride flow through U+A
    seed(5'd30, 1'b0, 32'd200, 32'd8);
    run_op(ADD, 5'd2, 5'd30, 5'd31, 1'b0);
    check("R2 affine seed", CA, 32'd209, 32'd8, 1'b0, 1'b0, 5'd31);
    op_valid = 1'b0;
    @(negedge clk);

    // R1: synchronous reset returns all tags to vector
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_op(ADD, 5'd1, 5'd2, 5'd5, 1'b0);
    check("R1 after reset", CV, 0, 0, 1'b0, 1'b0, 5'd5);
    op_valid = 1'b0;
    @(negedge clk);

    finish_run();
  end

endmodule